// File: doc/BRIEF.md
# Asynchronous Static RAM Bridge

This block connects a clocked host to an external asynchronous static RAM of 512K words by 16 bits. The RAM has active-low chip select, output enable and write enable, plus a separate active-low enable for each byte lane. The host sends single-cycle requests over a valid/ready handshake. Each request carries an address, write data, a two-bit lane mask and a read/write flag. The bridge turns each request into a strobe sequence on the memory pins. For reads it returns the captured word with a one-cycle valid pulse.

Every analog limit is converted to whole clock cycles at elaboration. The conversion rounds each nanosecond figure up, using a clock-period parameter. A single parameter selects between a fast and a slow grade of memory. The fast grade has a 55 ns cycle, 40 ns write pulse, 25 ns data setup, 25 ns output-enable access and 20 ns output float. The slow grade has a 70 ns cycle, 50 ns pulse, 30 ns setup, 35 ns output-enable access and 25 ns float. Address access time equals the cycle time in both grades.

The shared data bus is split into an output word, an output-enable flag and an input word. These are joined by a tristate buffer outside the block.

Top module: `asram_bridge`

## Requirements
- R1: While reset is high and in the cycle after it, chip select, output enable, write enable and both lane enables are high, the data driver is off, rsp_valid is low and req_ready is high.
- R2: A read is accepted when req_valid and req_ready are both high at a clock edge and the mask is nonzero. From the next cycle the bridge holds the address, chip select low, output enable low and write enable high for N_RD cycles. N_RD is the largest of ceil(access/period), ceil(output-enable access/period) and ceil(cycle/period).
- R3: Read data is sampled on the last cycle of the read window. rsp_valid is high for the one cycle right after the window, with that data on rsp_rdata. Lanes that were not enabled read as zero.
- R4: An accepted write with a nonzero mask does the following from the next cycle, for N_WR = max(ceil(pulse/period), ceil(setup/period)) cycles. It holds the address, chip select low, write enable low and output enable high, and it drives the write data with the driver on. After that, chip select, write enable, the lane enables and the driver all turn off in the same cycle.
- R5: Mask bit 0 enables the lower lane (data bits 7..0, lower enable pin) and mask bit 1 enables the upper lane (bits 15..8, upper enable pin). Whenever chip select is low, at least one lane enable is low. A lane whose mask bit is clear is left unchanged by a write.
- R6: After a read window, the strobes stay high, the driver stays off and req_ready stays low for N_FLT = ceil(float/period) cycles. As a result, the driver never turns on within N_FLT cycles of output enable rising.
- R7: After a write, req_ready returns high exactly ceil(cycle/period) cycles after acceptance when that is larger than N_WR, and right after the write window otherwise.
- R8: A request with both mask bits clear causes no strobe activity and keeps req_ready high. For a read, rsp_valid pulses in the next cycle with rsp_rdata zero.
- R9: req_ready is low whenever an access or its recovery is in progress. A request presented while req_ready is low has no effect.
- R10: With the slow-grade parameter set, all windows use the slow-grade limits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Bridge can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 lower byte, bit 1 upper byte |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 19 | Memory address bus |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper lane enable, active low |
| mem_lb_n | output | 1 | Lower lane enable, active low |
| mem_dq_out | output | 16 | Data driven toward memory |
| mem_dq_oe | output | 1 | Tristate enable for mem_dq_out |
| mem_dq_in | input | 16 | Data read from the memory bus |

## Verification
The bench runs writes directly after reads and reads directly after writes. A bridge that skipped the float recovery would switch its driver on while the memory still drives the bus, and would shorten the ready-low stretch that the model predicts. Single-lane writes followed by whole-word reads expose a swapped or ignored lane mask as a corrupted neighbour byte. Single-lane reads see a fill pattern on the unselected lane, so unmasked capture shows up as nonzero data. Zero-mask requests, requests poked while busy, and a second slow-grade instance catch strobes that toggle when they should not, requests accepted when busy, and window lengths taken from the wrong grade.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_GAP   = 2'd3
  } seq_state_e;

  function automatic int unsigned cdiv(int unsigned ns, int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned imax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Grade-dependent limits in nanoseconds
  function automatic int unsigned ns_cycle(bit slow);
    return slow ? 70 : 55;
  endfunction

  function automatic int unsigned ns_pulse(bit slow);
    return slow ? 50 : 40;
  endfunction

  function automatic int unsigned ns_setup(bit slow);
    return slow ? 30 : 25;
  endfunction

  function automatic int unsigned ns_oe_acc(bit slow);
    return slow ? 35 : 25;
  endfunction

  function automatic int unsigned ns_float(bit slow);
    return slow ? 25 : 20;
  endfunction

  // Cycle counts
  function automatic int unsigned cyc_cycles(int unsigned clk_ns, bit slow);
    return cdiv(ns_cycle(slow), clk_ns);
  endfunction

  function automatic int unsigned rd_cycles(int unsigned clk_ns, bit slow);
    return imax(cdiv(ns_cycle(slow), clk_ns), cdiv(ns_oe_acc(slow), clk_ns));
  endfunction

  function automatic int unsigned wr_cycles(int unsigned clk_ns, bit slow);
    return imax(cdiv(ns_pulse(slow), clk_ns), cdiv(ns_setup(slow), clk_ns));
  endfunction

  function automatic int unsigned wpad_cycles(int unsigned clk_ns, bit slow);
    int unsigned c;
    int unsigned w;
    c = cyc_cycles(clk_ns, slow);
    w = wr_cycles(clk_ns, slow);
    return (c > w) ? (c - w) : 0;
  endfunction

  function automatic int unsigned flt_cycles(int unsigned clk_ns, bit slow);
    return cdiv(ns_float(slow), clk_ns);
  endfunction

endpackage

// File: rtl/asram_tmr.sv
module asram_tmr #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int unsigned MW     = 2,
  parameter int unsigned N_RD   = 6,
  parameter int unsigned N_WR   = 4,
  parameter int unsigned N_WPAD = 2,
  parameter int unsigned N_FLT  = 2,
  parameter int unsigned CW     = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [MW-1:0] req_mask,
  output logic          req_ready,
  output logic          go_rd,
  output logic          go_wr,
  output logic          null_rd,
  output logic          fin_rd,
  output logic          fin_wr
);

  localparam bit          HAS_PAD = (N_WPAD > 0);
  localparam int unsigned PAD_LD  = HAS_PAD ? N_WPAD - 1 : 0;

  seq_state_e    st_q, st_d;
  logic          ld;
  logic [CW-1:0] ld_val;
  logic          tmr_zero;
  logic          accept;
  logic          any_lane;

  asram_tmr #(.CW(CW)) tmr_i (
    .clk      (clk),
    .rst      (rst),
    .load     (ld),
    .load_val (ld_val),
    .zero     (tmr_zero)
  );

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign any_lane  = |req_mask;
  assign go_rd     = accept && !req_write && any_lane;
  assign go_wr     = accept &&  req_write && any_lane;
  assign null_rd   = accept && !req_write && !any_lane;
  assign fin_rd    = (st_q == ST_READ)  && tmr_zero;
  assign fin_wr    = (st_q == ST_WRITE) && tmr_zero;

  always_comb begin
    st_d   = st_q;
    ld     = 1'b0;
    ld_val = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (go_rd) begin
          st_d   = ST_READ;
          ld     = 1'b1;
          ld_val = CW'(N_RD - 1);
        end else if (go_wr) begin
          st_d   = ST_WRITE;
          ld     = 1'b1;
          ld_val = CW'(N_WR - 1);
        end
      end
      ST_READ: begin
        if (tmr_zero) begin
          st_d   = ST_GAP;
          ld     = 1'b1;
          ld_val = CW'(N_FLT - 1);
        end
      end
      ST_WRITE: begin
        if (tmr_zero) begin
          if (HAS_PAD) begin
            st_d   = ST_GAP;
            ld     = 1'b1;
            ld_val = CW'(PAD_LD);
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
      ST_GAP: begin
        if (tmr_zero) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

endmodule

// File: rtl/asram_pins.sv
module asram_pins #(
  parameter int unsigned AW = 19,
  parameter int unsigned DW = 16,
  parameter int unsigned MW = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go_rd,
  input  logic          go_wr,
  input  logic          null_rd,
  input  logic          fin_rd,
  input  logic          fin_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [MW-1:0] req_mask,
  input  logic [DW-1:0] mem_dq_in,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [MW-1:0] mem_be_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe
);

  logic [MW-1:0] lane_q;
  logic [DW-1:0] rd_masked;

  // Unselected lanes are returned as zero
  for (genvar g = 0; g < MW; g++) begin : g_lane
    assign rd_masked[8*g +: 8] = lane_q[g] ? mem_dq_in[8*g +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_q     <= '0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      mem_addr   <= '0;
      mem_cs_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_be_n   <= '1;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (go_rd) begin
        lane_q   <= req_mask;
        mem_addr <= req_addr;
        mem_cs_n <= 1'b0;
        mem_oe_n <= 1'b0;
        mem_we_n <= 1'b1;
        mem_be_n <= ~req_mask;
      end
      if (go_wr) begin
        lane_q     <= req_mask;
        mem_addr   <= req_addr;
        mem_cs_n   <= 1'b0;
        mem_oe_n   <= 1'b1;
        mem_we_n   <= 1'b0;
        mem_be_n   <= ~req_mask;
        mem_dq_out <= req_wdata;
        mem_dq_oe  <= 1'b1;
      end
      if (fin_rd) begin
        mem_cs_n  <= 1'b1;
        mem_oe_n  <= 1'b1;
        mem_be_n  <= '1;
        rsp_valid <= 1'b1;
        rsp_rdata <= rd_masked;
      end
      if (fin_wr) begin
        mem_cs_n  <= 1'b1;
        mem_we_n  <= 1'b1;
        mem_be_n  <= '1;
        mem_dq_oe <= 1'b0;
      end
      if (null_rd) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= '0;
      end
    end
  end

endmodule

// File: rtl/asram_bridge.sv
module asram_bridge
  import asram_pkg::*;
#(
  parameter int unsigned AW         = 19,
  parameter int unsigned DW         = 16,
  parameter int unsigned CLK_NS     = 10,
  parameter bit          SLOW_GRADE = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic [DW/8-1:0] req_mask,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_rdata,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_cs_n,
  output logic            mem_oe_n,
  output logic            mem_we_n,
  output logic            mem_ub_n,
  output logic            mem_lb_n,
  output logic [DW-1:0]   mem_dq_out,
  output logic            mem_dq_oe,
  input  logic [DW-1:0]   mem_dq_in
);

  localparam int unsigned MW     = DW / 8;
  localparam int unsigned N_RD   = rd_cycles(CLK_NS, SLOW_GRADE);
  localparam int unsigned N_WR   = wr_cycles(CLK_NS, SLOW_GRADE);
  localparam int unsigned N_WPAD = wpad_cycles(CLK_NS, SLOW_GRADE);
  localparam int unsigned N_FLT  = flt_cycles(CLK_NS, SLOW_GRADE);
  localparam int unsigned N_MAX  = imax(imax(N_RD, N_WR), imax(N_WPAD, N_FLT));
  localparam int unsigned CW     = $clog2(N_MAX + 1);

  logic          go_rd, go_wr, null_rd, fin_rd, fin_wr;
  logic [MW-1:0] be_n;

  asram_seq #(
    .MW     (MW),
    .N_RD   (N_RD),
    .N_WR   (N_WR),
    .N_WPAD (N_WPAD),
    .N_FLT  (N_FLT),
    .CW     (CW)
  ) seq_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_mask  (req_mask),
    .req_ready (req_ready),
    .go_rd     (go_rd),
    .go_wr     (go_wr),
    .null_rd   (null_rd),
    .fin_rd    (fin_rd),
    .fin_wr    (fin_wr)
  );

  asram_pins #(
    .AW (AW),
    .DW (DW),
    .MW (MW)
  ) pins_i (
    .clk        (clk),
    .rst        (rst),
    .go_rd      (go_rd),
    .go_wr      (go_wr),
    .null_rd    (null_rd),
    .fin_rd     (fin_rd),
    .fin_wr     (fin_wr),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_mask   (req_mask),
    .mem_dq_in  (mem_dq_in),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .mem_addr   (mem_addr),
    .mem_cs_n   (mem_cs_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_be_n   (be_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
  );

  assign mem_ub_n = be_n[MW-1];
  assign mem_lb_n = be_n[0];

endmodule

// File: rtl/asram_bridge_chk.sv
module asram_bridge_chk
  import asram_pkg::*;
#(
  parameter int unsigned CLK_NS     = 10,
  parameter bit          SLOW_GRADE = 1'b0
) (
  input logic clk,
  input logic rst,
  input logic req_ready,
  input logic rsp_valid,
  input logic mem_cs_n,
  input logic mem_oe_n,
  input logic mem_we_n,
  input logic mem_ub_n,
  input logic mem_lb_n,
  input logic mem_dq_oe
);

  localparam int unsigned C_WR  = wr_cycles(CLK_NS, SLOW_GRADE);
  localparam int unsigned C_FLT = flt_cycles(CLK_NS, SLOW_GRADE);

  logic [7:0] oe_hi_cnt;
  logic [7:0] we_lo_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_hi_cnt <= 8'hFF;
      we_lo_cnt <= 8'h00;
    end else begin
      if (!mem_oe_n)            oe_hi_cnt <= 8'h00;
      else if (oe_hi_cnt != 8'hFF) oe_hi_cnt <= oe_hi_cnt + 8'h01;
      if (!mem_we_n)            we_lo_cnt <= we_lo_cnt + 8'h01;
      else                      we_lo_cnt <= 8'h00;
    end
  end

  // R2
  read_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (mem_we_n && !mem_dq_oe));

  // R4
  drive_in_write_chk: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (!mem_we_n && !mem_cs_n && mem_oe_n));

  // R4
  write_pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_lo_cnt == 8'(C_WR)));

  // R3
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_oe_n) |-> rsp_valid);

  // R5
  lane_active_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_cs_n |-> !(mem_ub_n && mem_lb_n));

  // R6
  float_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> (oe_hi_cnt >= 8'(C_FLT)));

  // R9
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_cs_n |-> !req_ready);

endmodule

bind asram_bridge asram_bridge_chk #(
  .CLK_NS     (CLK_NS),
  .SLOW_GRADE (SLOW_GRADE)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_cs_n  (mem_cs_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_ub_n  (mem_ub_n),
  .mem_lb_n  (mem_lb_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/asram_bridge_tb_top.sv
module asram_bridge_tb_top;

  localparam int CLK_NS = 4;

  function automatic int cd(int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // Fast grade expectations
  localparam int F_RD  = mx(cd(55), cd(25));
  localparam int F_WR  = mx(cd(40), cd(25));
  localparam int F_CYC = mx(cd(55), F_WR);
  localparam int F_FLT = cd(20);
  // Slow grade expectations
  localparam int S_RD  = mx(cd(70), cd(35));
  localparam int S_WR  = mx(cd(50), cd(30));
  localparam int S_CYC = mx(cd(70), S_WR);
  localparam int S_FLT = cd(25);

  localparam logic [2:0] K_IDLE = 3'd0, K_RD = 3'd1, K_WR = 3'd2,
                         K_GR = 3'd3, K_GW = 3'd4, K_NULL = 3'd5;

  typedef struct packed {
    logic [2:0]  kind;
    logic        ready;
    logic        rsp;
    logic        ub_n;
    logic        lb_n;
    logic [18:0] addr;
    logic [15:0] wdata;
    logic [15:0] rdata;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_NS / 2) clk = ~clk;

  // Fast instance signals
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [18:0] mem_addr;
  logic        mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe;
  logic [15:0] mem_dq_out;
  logic [15:0] mem_dq_in = 16'h5A5A;

  // Slow instance signals
  logic        s_valid = 1'b0, s_write = 1'b0;
  logic [18:0] s_addr = '0;
  logic [15:0] s_wdata = '0;
  logic [1:0]  s_mask = '0;
  logic        s_ready, s_rsp_valid;
  logic [15:0] s_rdata;
  logic [18:0] s_maddr;
  logic        s_cs_n, s_oe_n, s_we_n, s_ub_n, s_lb_n, s_dq_oe;
  logic [15:0] s_dq_out;

  asram_bridge #(.CLK_NS(CLK_NS), .SLOW_GRADE(1'b0)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  asram_bridge #(.CLK_NS(CLK_NS), .SLOW_GRADE(1'b1)) dut_slow_i (
    .clk(clk), .rst(rst), .req_valid(s_valid), .req_ready(s_ready),
    .req_write(s_write), .req_addr(s_addr), .req_wdata(s_wdata),
    .req_mask(s_mask), .rsp_valid(s_rsp_valid), .rsp_rdata(s_rdata),
    .mem_addr(s_maddr), .mem_cs_n(s_cs_n), .mem_oe_n(s_oe_n),
    .mem_we_n(s_we_n), .mem_ub_n(s_ub_n), .mem_lb_n(s_lb_n),
    .mem_dq_out(s_dq_out), .mem_dq_oe(s_dq_oe), .mem_dq_in(16'hC3A5)
  );

  int n_chk = 0;
  int n_err = 0;
  bit started = 1'b0;
  bit done = 1'b0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // Reference memory and emulated RAM
  logic [15:0] ref_mem [int];
  logic [15:0] ram [int];

  function automatic logic [15:0] ref_rd(int a);
    return ref_mem.exists(a) ? ref_mem[a] : 16'h0000;
  endfunction
  function automatic logic [15:0] ram_rd(int a);
    return ram.exists(a) ? ram[a] : 16'h0000;
  endfunction

  function automatic exp_t idle_e();
    exp_t e;
    e = '0;
    e.kind = K_IDLE; e.ready = 1'b1; e.ub_n = 1'b1; e.lb_n = 1'b1;
    return e;
  endfunction

  // Cycle model: queue of expected per-cycle outputs
  exp_t q[$];
  exp_t cur;

  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      cur = idle_e();
    end else begin
      if (req_valid && cur.ready) begin
        exp_t e;
        logic [15:0] old;
        e = idle_e();
        e.ready = 1'b0;
        old = ref_rd(int'(req_addr));
        if (req_mask == 2'b00) begin
          if (!req_write) begin
            e.kind = K_NULL; e.ready = 1'b1; e.rsp = 1'b1; e.rdata = 16'h0000;
            q.push_back(e);
          end
        end else if (!req_write) begin
          e.kind = K_RD; e.addr = req_addr;
          e.ub_n = !req_mask[1]; e.lb_n = !req_mask[0];
          for (int i = 0; i < F_RD; i++) q.push_back(e);
          e.kind = K_GR; e.ub_n = 1'b1; e.lb_n = 1'b1;
          for (int i = 0; i < F_FLT; i++) begin
            e.rsp = (i == 0);
            e.rdata = {req_mask[1] ? old[15:8] : 8'h00, req_mask[0] ? old[7:0] : 8'h00};
            q.push_back(e);
          end
        end else begin
          ref_mem[int'(req_addr)] = {req_mask[1] ? req_wdata[15:8] : old[15:8],
                                     req_mask[0] ? req_wdata[7:0]  : old[7:0]};
          e.kind = K_WR; e.addr = req_addr; e.wdata = req_wdata;
          e.ub_n = !req_mask[1]; e.lb_n = !req_mask[0];
          for (int i = 0; i < F_WR; i++) q.push_back(e);
          e.kind = K_GW; e.ub_n = 1'b1; e.lb_n = 1'b1;
          for (int i = 0; i < F_CYC - F_WR; i++) q.push_back(e);
        end
      end
      cur = (q.size() > 0) ? q.pop_front() : idle_e();
    end
  end

  // Per-cycle compare plus RAM emulation, mid-cycle
  logic        pw_act = 1'b0;
  logic [18:0] pw_addr;
  logic [15:0] pw_data;
  logic        pw_ub, pw_lb;

  always @(negedge clk) begin
    if (started && !rst) begin
      string st;
      logic is_rd, is_wr;
      is_rd = (cur.kind == K_RD);
      is_wr = (cur.kind == K_WR);
      case (cur.kind)
        K_RD:    st = "R2";
        K_WR:    st = "R4";
        K_GR:    st = "R6";
        K_GW:    st = "R7";
        K_NULL:  st = "R8";
        default: st = "R9";
      endcase
      chk(st, "cs_n", mem_cs_n, !(is_rd || is_wr));
      chk(st, "oe_n", mem_oe_n, !is_rd);
      chk(st, "we_n", mem_we_n, !is_wr);
      chk(st, "dq_oe", mem_dq_oe, is_wr);
      chk("R5", "ub_n", mem_ub_n, cur.ub_n);
      chk("R5", "lb_n", mem_lb_n, cur.lb_n);
      chk("R9", "ready", req_ready, cur.ready);
      chk((cur.kind == K_NULL) ? "R8" : "R3", "rsp_valid", rsp_valid, cur.rsp);
      if (cur.rsp) chk((cur.kind == K_NULL) ? "R8" : "R3", "rdata", rsp_rdata, cur.rdata);
      if (is_rd || is_wr) chk(st, "addr", mem_addr, cur.addr);
      if (is_wr) chk("R4", "dq_out", mem_dq_out, cur.wdata);
    end
    // End of write: commit enabled lanes to emulated RAM
    if (pw_act && !(!mem_cs_n && !mem_we_n)) begin
      logic [15:0] o;
      o = ram_rd(int'(pw_addr));
      ram[int'(pw_addr)] = {pw_ub ? pw_data[15:8] : o[15:8], pw_lb ? pw_data[7:0] : o[7:0]};
    end
    pw_act  = !mem_cs_n && !mem_we_n && mem_dq_oe;
    pw_addr = mem_addr;
    pw_data = mem_dq_out;
    pw_ub   = !mem_ub_n;
    pw_lb   = !mem_lb_n;
    if (!mem_cs_n && !mem_oe_n && mem_we_n) begin
      logic [15:0] r;
      r = ram_rd(int'(mem_addr));
      mem_dq_in = {!mem_ub_n ? r[15:8] : 8'h5A, !mem_lb_n ? r[7:0] : 8'h5A};
    end else begin
      mem_dq_in = 16'h5A5A;
    end
  end

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000 && !done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  // Called at a negedge; returns at the negedge after acceptance
  task automatic issue(input logic wr, input logic [18:0] a,
                       input logic [15:0] d, input logic [1:0] m);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Slow-grade directed access: counts cycles after acceptance
  task automatic slow_access(input logic wr, input logic [1:0] m,
                             output int low_cnt, output int we_cnt,
                             output int oe_cnt, output logic [15:0] got);
    s_valid = 1'b1; s_write = wr; s_addr = 19'h00ABC; s_wdata = 16'h1234; s_mask = m;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
    low_cnt = 0; we_cnt = 0; oe_cnt = 0; got = 16'hFFFF;
    while (!s_ready && low_cnt < 200) begin
      low_cnt++;
      if (!s_we_n) we_cnt++;
      if (!s_oe_n) oe_cnt++;
      if (s_rsp_valid) got = s_rdata;
      @(negedge clk);
    end
  endtask

  initial begin
    int lo, wc, oc;
    logic [15:0] g;
    settle(3);
    // R1: reset state during reset
    chk("R1", "cs_n", mem_cs_n, 1'b1);
    chk("R1", "oe_n", mem_oe_n, 1'b1);
    chk("R1", "we_n", mem_we_n, 1'b1);
    chk("R1", "be_n", {mem_ub_n, mem_lb_n}, 2'b11);
    chk("R1", "dq_oe", mem_dq_oe, 1'b0);
    chk("R1", "rsp_valid", rsp_valid, 1'b0);
    chk("R1", "ready", req_ready, 1'b1);
    chk("R1", "slow cs_n", s_cs_n, 1'b1);
    rst = 1'b0;
    started = 1'b1;
    settle(2);

    // R2 R4: word write then word read
    issue(1'b1, 19'h12345, 16'hBEEF, 2'b11);
    issue(1'b0, 19'h12345, 16'h0000, 2'b11);
    // R5: lower then upper lane writes, word read back
    issue(1'b1, 19'h12345, 16'h0011, 2'b01);
    issue(1'b0, 19'h12345, 16'h0000, 2'b11);
    issue(1'b1, 19'h12345, 16'h7700, 2'b10);
    // R3: single-lane reads zero the other lane
    issue(1'b0, 19'h12345, 16'h0000, 2'b10);
    issue(1'b0, 19'h12345, 16'h0000, 2'b01);
    // R8: zero-mask write and reads
    issue(1'b1, 19'h12345, 16'hFFFF, 2'b00);
    issue(1'b0, 19'h12345, 16'h0000, 2'b00);
    issue(1'b0, 19'h00001, 16'h0000, 2'b00);
    issue(1'b0, 19'h12345, 16'h0000, 2'b11);
    settle(3);
    // R6 R7: turnarounds at address extremes
    issue(1'b1, 19'h00000, 16'hA5C3, 2'b11);
    issue(1'b1, 19'h7FFFF, 16'h0F0F, 2'b11);
    issue(1'b0, 19'h00000, 16'h0000, 2'b11);
    issue(1'b1, 19'h00000, 16'h1200, 2'b10);
    issue(1'b0, 19'h7FFFF, 16'h0000, 2'b11);
    issue(1'b0, 19'h00000, 16'h0000, 2'b11);
    // R9: a request poked while busy must be ignored
    issue(1'b0, 19'h7FFFF, 16'h0000, 2'b11);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h7FFFF; req_wdata = 16'h0000; req_mask = 2'b11;
    @(negedge clk);
    req_valid = 1'b0;
    settle(F_RD + F_FLT + 2);
    issue(1'b0, 19'h7FFFF, 16'h0000, 2'b11);
    settle(F_CYC + F_FLT + 4);

    // R10: slow grade windows
    slow_access(1'b1, 2'b11, lo, wc, oc, g);
    chk("R10", "slow write pulse", wc, S_WR);
    chk("R10", "slow write busy", lo, S_CYC);
    slow_access(1'b0, 2'b11, lo, wc, oc, g);
    chk("R10", "slow read window", oc, S_RD);
    chk("R10", "slow read busy", lo, S_RD + S_FLT);
    chk("R10", "slow read data", g, 16'hC3A5);
    slow_access(1'b0, 2'b10, lo, wc, oc, g);
    chk("R10", "slow upper read data", g, 16'hC300);

    settle(4);
    done = 1'b1;
    finish_run();
  end

endmodule